// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a clocked cycle controller in front of a small word-organised memory. It behaves like a synchronous burst SRAM. On every rising clock edge it samples three chip enables, a sleep request, two address strobes (one driven from the processor side, one from the memory-controller side), a burst-advance input and a group of write enables. From these it classifies the cycle as sleep, deselect, new burst from the external address, burst continue, or burst suspend. It then performs a byte-masked write or a registered read.

The two low address bits form a burst counter. The counter wraps inside an aligned group of four words and keeps its value across suspend, deselect and sleep cycles. The upper address bits are taken from the address input only when a new burst starts. Read data is registered and is presented after the sampling edge. Output enable gates the read data driver combinationally, without any clock involvement.

Top module: `burst_sram_ctl`

## Requirements
- R1: The part is selected only when `en_pri_n`=0, `en_sec`=1 and `en_ter_n`=0. A cycle in which `en_pri_n`=0, the selection is not met and either strobe is low is a deselect, and after it `rdata_drv` is 0.
- R2: While `en_pri_n`=1 the processor strobe `strb_cpu_n` has no effect. A low `strb_ctl_n` makes the cycle a deselect. With `strb_ctl_n`=1 the cycle is a burst continue or a burst suspend, selected by `adv_n`.
- R3: With `sleep`=1 every other synchronous input is ignored, `rdata_drv` is 0 after the edge, and the burst address is left unchanged.
- R4: Selected with `strb_cpu_n`=0, the cycle is a read from `addr`, whatever the write enables are.
- R5: Selected with `strb_cpu_n`=1 and `strb_ctl_n`=0, the cycle starts a burst at `addr`. It is a write if the combined write is active and a read otherwise.
- R6: The combined write is active when `wr_all_n`=0, or when `wr_byte_n`=0 and at least one bit of `lane_n` is 0.
- R7: With both strobes inactive and `adv_n`=0, the cycle uses the next address. Only the two low bits step, modulo 4, and the upper bits are kept.
- R8: With both strobes inactive and `adv_n`=1, the cycle reuses the current burst address.
- R9: A write updates byte lane k (`wdata` bits [8k+7:8k]) only when `lane_n[k]`=0. When `wr_all_n`=0, every lane is written.
- R10: The data of a read cycle is on `rdata` right after the edge that sampled the cycle and stays there until the next edge.
- R11: `rdata_drv` is 1 only when the last sampled cycle was a read and `oe_n`=0 at that moment. `oe_n` acts without a clock, and it is masked after write, deselect and sleep cycles.
- R12: After reset `rdata_drv` is 0 and the burst address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_pri_n | input | 1 | Primary chip enable, active low |
| en_sec | input | 1 | Second chip enable, active high |
| en_ter_n | input | 1 | Third chip enable, active low |
| sleep | input | 1 | Sleep request, overrides all else |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drv | output | 1 | Read data driver enable |

## Verification
The assertions assume that reset has been released for at least one edge before a history-based check applies. They also assume that the strobe, enable and write inputs are stable around each rising edge. The bench keeps within this by changing every synchronous input only on the falling edge and by moving `oe_n` only between edges. The assertions state nothing about memory contents. Those are left to the bench's reference array, which is written through every decode row before it is read back.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // classification of a sampled clock edge
    typedef enum logic [2:0] {
        K_SLEEP = 3'd0,
        K_DESEL = 3'd1,
        K_NEW   = 3'd2,
        K_NEXT  = 3'd3,
        K_HOLD  = 3'd4
    } kind_e;

    // operation carried out by a cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
    import bsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             en_pri_n,
    input  logic             en_sec,
    input  logic             en_ter_n,
    input  logic             sleep,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_n,
    output kind_e            kind,
    output op_e              op,
    output logic [LANES-1:0] lane_we
);

    logic selected;
    logic wr_req;
    op_e  rw_op;

    always_comb begin
        selected = !en_pri_n && en_sec && !en_ter_n;
        // combined write: global, or byte-write with any lane requested
        wr_req   = !wr_all_n || (!wr_byte_n && (lane_n != {LANES{1'b1}}));
        rw_op    = wr_req ? OP_WR : OP_RD;

        if (!wr_all_n) begin
            lane_we = {LANES{1'b1}};
        end else if (!wr_byte_n) begin
            lane_we = ~lane_n;
        end else begin
            lane_we = '0;
        end
    end

    always_comb begin
        kind = K_DESEL;
        op   = OP_NONE;
        if (sleep) begin
            kind = K_SLEEP;
            op   = OP_NONE;
        end else if (en_pri_n) begin
            // processor strobe plays no part here
            if (!strb_ctl_n) begin
                kind = K_DESEL;
                op   = OP_NONE;
            end else begin
                kind = adv_n ? K_HOLD : K_NEXT;
                op   = rw_op;
            end
        end else if (!strb_cpu_n) begin
            if (selected) begin
                kind = K_NEW;
                op   = OP_RD;
            end else begin
                kind = K_DESEL;
                op   = OP_NONE;
            end
        end else if (!strb_ctl_n) begin
            if (selected) begin
                kind = K_NEW;
                op   = rw_op;
            end else begin
                kind = K_DESEL;
                op   = OP_NONE;
            end
        end else begin
            kind = adv_n ? K_HOLD : K_NEXT;
            op   = rw_op;
        end
    end

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int HI_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [CNT_W-1:0] lo;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            K_NEW:   cur_addr = ext_addr;
            K_NEXT:  cur_addr = {st_q.hi, CNT_W'(st_q.lo + 1'b1)};
            default: cur_addr = {st_q.hi, st_q.lo};
        endcase
        if (kind == K_NEW || kind == K_NEXT || kind == K_HOLD) begin
            st_d.hi = cur_addr[ADDR_W-1:CNT_W];
            st_d.lo = cur_addr[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    re,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] rd_d, rd_q;

        always_comb begin
            rd_d = re ? cells[addr] : rd_q;
        end

        always_ff @(posedge clk) begin
            if (we && lane_we[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            rd_q <= rd_d;
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_pri_n,
    input  logic                    en_sec,
    input  logic                    en_ter_n,
    input  logic                    sleep,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drv
);

    localparam int CNT_W = 2;

    typedef struct packed {
        op_e last_op;
    } ctl_t;

    kind_e             cyc_kind;
    op_e               cyc_op;
    logic [LANES-1:0]  cyc_lanes;
    logic [ADDR_W-1:0] cyc_addr;
    ctl_t              ctl_d, ctl_q;

    bsram_decode #(.LANES(LANES)) u_decode (
        .en_pri_n   (en_pri_n),
        .en_sec     (en_sec),
        .en_ter_n   (en_ter_n),
        .sleep      (sleep),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_n     (lane_n),
        .kind       (cyc_kind),
        .op         (cyc_op),
        .lane_we    (cyc_lanes)
    );

    bsram_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (cyc_kind),
        .ext_addr (addr),
        .cur_addr (cyc_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (cyc_op == OP_WR),
        .re      (cyc_op == OP_RD),
        .lane_we (cyc_lanes),
        .addr    (cyc_addr),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.last_op = cyc_op;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{last_op: OP_NONE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // output enable is applied without any clock
    assign rdata_drv = (ctl_q.last_op == OP_RD) && !oe_n;

endmodule

// File: rtl/bsram_checks.sv
module bsram_checks
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_pri_n,
    input logic              en_sec,
    input logic              en_ter_n,
    input logic              sleep,
    input logic              strb_cpu_n,
    input logic              strb_ctl_n,
    input logic              wr_all_n,
    input logic              oe_n,
    input logic              rdata_drv,
    input kind_e             cyc_kind,
    input logic [ADDR_W-1:0] cyc_addr
);

    a_r3_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rdata_drv);

    a_r1_unselected_desel: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !en_pri_n && !(en_sec && !en_ter_n) && (!strb_cpu_n || !strb_ctl_n))
        |=> !rdata_drv);

    a_r2_ctl_strobe_desel: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && en_pri_n && !strb_ctl_n) |=> !rdata_drv);

    a_r4_cpu_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !en_pri_n && en_sec && !en_ter_n && !strb_cpu_n)
        |=> (oe_n || rdata_drv));

    a_r11_write_masks_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !en_pri_n && en_sec && !en_ter_n && strb_cpu_n && !strb_ctl_n && !wr_all_n)
        |=> !rdata_drv);

    a_r8_suspend_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cyc_kind == K_HOLD && $past(cyc_kind) == K_HOLD)
        |-> cyc_addr == $past(cyc_addr));

    a_r7_continue_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cyc_kind == K_NEXT &&
         ($past(cyc_kind) == K_NEW || $past(cyc_kind) == K_NEXT || $past(cyc_kind) == K_HOLD))
        |-> (cyc_addr[ADDR_W-1:2] == $past(cyc_addr[ADDR_W-1:2]) &&
             cyc_addr[1:0] == 2'($past(cyc_addr[1:0]) + 2'd1)));

endmodule

bind burst_sram_ctl bsram_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_pri_n   (en_pri_n),
    .en_sec     (en_sec),
    .en_ter_n   (en_ter_n),
    .sleep      (sleep),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .wr_all_n   (wr_all_n),
    .oe_n       (oe_n),
    .rdata_drv  (rdata_drv),
    .cyc_kind   (cyc_kind),
    .cyc_addr   (cyc_addr)
);

// File: tb/burst_sram_ctl_test.sv
module burst_sram_ctl_test;

    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_pri_n = 1'b1, en_sec = 1'b0, en_ter_n = 1'b1, sleep = 1'b1;
    logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
    logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [1:0]    lane_n = 2'b11;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [DW-1:0] ref_mem [64];
    logic [3:0]    m_hi;
    logic [1:0]    m_lo;
    bit            m_rd;
    logic [DW-1:0] m_data;

    burst_sram_ctl #(.ADDR_W(AW), .LANES(2), .LANE_W(8)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_out(string tag);
        bit exp_drv;
        exp_drv = m_rd && !oe_n;
        chk(tag, "rdata_drv", {15'd0, rdata_drv}, {15'd0, exp_drv});
        if (exp_drv) chk({tag, "/R10"}, "rdata", rdata, m_data);
    endtask

    function automatic logic [DW-1:0] pat(int a);
        return 16'hA500 ^ DW'(a * 37);
    endfunction

    task automatic cyc(string tag, bit s, bit p, bit e2, bit e3n, bit cpu, bit ctl,
                       bit adv, bit gw, bit bwe, logic [1:0] bw, logic [AW-1:0] a,
                       logic [DW-1:0] wd);
        bit sel, wr;
        int op;  // 0 none, 1 read, 2 write
        logic [AW-1:0] ca;
        @(negedge clk);
        sleep = s; en_pri_n = p; en_sec = e2; en_ter_n = e3n;
        strb_cpu_n = cpu; strb_ctl_n = ctl; adv_n = adv;
        wr_all_n = gw; wr_byte_n = bwe; lane_n = bw; addr = a; wdata = wd;
        sel = !p && e2 && !e3n;
        wr  = !gw || (!bwe && bw != 2'b11);
        op  = 0;
        ca  = {m_hi, m_lo};
        if (s) op = 0;
        else if (p && !ctl) op = 0;
        else if (!p && !cpu) begin
            if (sel) begin op = 1; ca = a; end
        end else if (!p && !ctl) begin
            if (sel) begin op = wr ? 2 : 1; ca = a; end
        end else begin
            op = wr ? 2 : 1;
            ca = adv ? {m_hi, m_lo} : {m_hi, 2'(m_lo + 2'd1)};
        end
        if (op != 0) begin
            m_hi = ca[5:2];
            m_lo = ca[1:0];
        end
        if (op == 1) begin
            m_rd = 1'b1;
            m_data = ref_mem[ca];
        end else begin
            m_rd = 1'b0;
            if (op == 2) begin
                for (int k = 0; k < 2; k++)
                    if (!gw || (!bwe && !bw[k])) ref_mem[ca][k*8 +: 8] = wd[k*8 +: 8];
            end
        end
        @(posedge clk);
        #1;
        check_out(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        sleep = 1'b1;
        rst_n = 1'b0;
        m_hi = '0; m_lo = '0; m_rd = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R12", "rdata_drv in reset", {15'd0, rdata_drv}, 16'd0);
        rst_n = 1'b1;
    endtask

    // shorthands: selected begin via processor strobe, via controller strobe, and a burst step
    task automatic rd_cpu(string t, logic [AW-1:0] a);
        cyc(t, 0, 0, 1, 0, 0, 1, 1, 0, 0, 2'b00, a, 16'hDEAD);
    endtask
    task automatic new_ctl(string t, bit gw, bit bwe, logic [1:0] bw, logic [AW-1:0] a,
                           logic [DW-1:0] wd);
        cyc(t, 0, 0, 1, 0, 1, 0, 1, gw, bwe, bw, a, wd);
    endtask
    task automatic step(string t, bit adv, bit gw);
        cyc(t, 0, 0, 1, 0, 1, 1, adv, gw, 1, 2'b11, 6'h00, 16'h5A5A);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = 'x;
        do_reset();
        @(negedge clk);
        #1;
        chk("R12", "rdata_drv after reset", {15'd0, rdata_drv}, 16'd0);

        // fill the whole array through controller-strobe writes (global write)
        for (int a = 0; a < 64; a++) new_ctl("R5", 0, 1, 2'b11, AW'(a), pat(a));
        // read everything back via processor strobe with all writes asserted
        for (int a = 0; a < 64; a++) rd_cpu("R4", AW'(a));

        // burst continue with wrap, then suspend
        new_ctl("R5", 1, 1, 2'b11, 6'h16, 16'h0);
        for (int i = 0; i < 6; i++) step("R7", 0, 1);
        for (int i = 0; i < 3; i++) step("R8", 1, 1);

        // primary enable high: processor strobe ignored, controller strobe deselects
        cyc("R2", 0, 1, 1, 0, 0, 1, 0, 1, 1, 2'b11, 6'h3F, 16'h0);
        cyc("R2", 0, 1, 1, 0, 1, 0, 0, 1, 1, 2'b11, 6'h3F, 16'h0);
        cyc("R2", 0, 1, 0, 1, 1, 1, 0, 1, 1, 2'b11, 6'h3F, 16'h0);
        cyc("R2", 0, 1, 0, 1, 0, 1, 1, 1, 1, 2'b11, 6'h3F, 16'h0);

        // unselected combinations with the primary enable low
        for (int c = 0; c < 3; c++) begin
            bit e2, e3n;
            e2  = c[0];
            e3n = (c == 0) ? 1'b0 : 1'b1;
            rd_cpu("R4", AW'(8 + c));
            cyc("R1", 0, 0, e2, e3n, 0, 1, 1, 0, 0, 2'b00, 6'h30, 16'h0);
            step("R1", 1, 1);
            cyc("R1", 0, 0, e2, e3n, 1, 0, 1, 0, 1, 2'b11, 6'h31, 16'h1111);
            step("R1", 0, 1);
        end

        // sleep ignores everything, burst address kept
        rd_cpu("R4", 6'h21);
        cyc("R3", 1, 0, 1, 0, 0, 0, 0, 0, 0, 2'b00, 6'h05, 16'hFFFF);
        cyc("R3", 1, 0, 1, 0, 1, 0, 1, 0, 1, 2'b11, 6'h06, 16'hFFFF);
        step("R3", 1, 1);
        step("R3", 0, 1);

        // byte lanes and the combined write
        for (int m = 0; m < 4; m++) begin
            new_ctl("R9", 1, 0, 2'(m), 6'h05, 16'h1234 + 16'(m * 16'h1111));
            rd_cpu("R9", 6'h05);
        end
        new_ctl("R6", 1, 1, 2'b00, 6'h07, 16'hBEEF);
        rd_cpu("R6", 6'h07);
        new_ctl("R6", 1, 0, 2'b11, 6'h07, 16'hBEEF);
        rd_cpu("R6", 6'h07);
        new_ctl("R6", 0, 1, 2'b11, 6'h07, 16'hC0DE);
        step("R6", 1, 1);
        // burst write continue with global write, then read it back by suspend
        cyc("R7", 0, 0, 1, 0, 1, 1, 0, 0, 1, 2'b11, 6'h00, 16'h7777);
        step("R8", 1, 1);

        // output enable acts without a clock
        rd_cpu("R11", 6'h0A);
        @(negedge clk);
        oe_n = 1'b1; #1;
        chk("R11", "drv with oe high", {15'd0, rdata_drv}, 16'd0);
        oe_n = 1'b0; #1;
        chk("R11", "drv with oe low", {15'd0, rdata_drv}, 16'd1);
        chk("R10", "rdata held", rdata, ref_mem[10]);
        new_ctl("R11", 0, 1, 2'b11, 6'h0B, 16'h4242);

        // reset clears the burst address to zero, array keeps its data
        do_reset();
        step("R12", 1, 1);
        step("R12", 0, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule